// File: doc/BRIEF.md
# Pipelined Burst Bus Master Sequencer

This block is the master side of a 32-bit system bus on which every access has a start phase followed by one or more command phases. It takes a request made of a start address, a direction, a memory/IO select, a transfer count and a burst-enable bit. It then runs the transfers on the bus. Each transfer drives the address, byte enables, the memory/IO and direction selects and an active-low start strobe. The block reads the slave's width-claim lines, its burst-capable line and its ready line. It captures read data, or drives write data, and hands each word to or from the user side.

The block runs on an internal clock at twice the bus clock rate. One bus clock is therefore two internal cycles, and the bus clock midpoint is an internal clock edge. The first transfer of a request always takes a start phase and a command phase. The burst strobe is driven low from the middle of the first command phase under three conditions: the request asked for a burst, the slave reported burst capability at the end of that first start phase, and more than one word remains. After that, each further word takes one command phase with no start phase. When no burst is granted, each word is a standard start-plus-command cycle. The address of the next word is put on the bus at the midpoint of a command phase in which the slave reported ready. Write data from a standard cycle stays on the bus into the first half of the following bus clock.

Top module: `burst_bus_master`

## Requirements
- R1: A request is taken only when `req_ready` is high, `req_valid` is high and `req_count` is nonzero. `busy` then rises in the next cycle. A request with `req_count` of zero is ignored: `busy` stays low.
- R2: Every start phase lasts exactly two internal cycles with `start_n` low. The phase drives address `req_addr + 4*k` for word k, with `bus_mio` equal to the request's `req_mem` and all `bus_be_n` bits low. When idle, `bus_be_n` is all ones.
- R3: At the end of a start phase the block samples `ex16_n` and `ex32_n`. If both are high, the request is abandoned: no command phase follows, `busy` falls and `err` goes high. `err` stays high until the next request is taken. `done` does not pulse.
- R4: `exrdy` is sampled only at the edge that closes the first half of a command phase. When it is low, that command phase is repeated (two more internal cycles), the address is not advanced and no word is completed.
- R5: When `exrdy` is high at that midpoint and more words remain, the address advances by 4 from the second half of that command phase on. When `exrdy` is high on the final word, the address holds.
- R6: Burst is granted only at the end of the first start phase of a request, and only if `req_burst` was set, `slburst_n` is low and the count is at least 2. When granted, `msburst_n` is low from the second half of the first command phase onward, and later words take one command phase each with no start phase. When burst is not granted, `msburst_n` stays high and every word gets its own start phase.
- R7: In a burst, `msburst_n` is high in the second half of the command phase in which the final word completes.
- R8: `bus_write` does not change while `busy` is high.
- R9: For a read, `rd_valid` pulses for one cycle right after each completing edge. `rd_data` holds the `bus_din` value sampled at that edge. Words arrive in address order.
- R10: A write drives `bus_doe` from the second half of each start phase. For word k it drives the k-th value taken from `wr_data`, and `wr_pop` pulses once per word taken. Inside a burst the next word goes on the bus at the edge that completes the previous one. A read never raises `bus_doe`.
- R11: After a standard write word completes, `bus_doe` stays high with unchanged `bus_dout` for one more internal cycle. After the final burst word completes, `bus_doe` drops at once.
- R12: `done` pulses for one cycle in the first idle cycle after the final word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = IO space |
| req_count | input | 8 | Number of 32-bit words |
| req_burst | input | 1 | Permit burst for this request |
| wr_data | input | 32 | Next write word, taken when the block loads it |
| wr_pop | output | 1 | One-cycle pulse after a write word was taken |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse with each read word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse after the last word |
| err | output | 1 | Last request was abandoned because no slave claimed it |
| bus_addr | output | 32 | Bus address |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_mio | output | 1 | Memory/IO select |
| bus_write | output | 1 | Direction select |
| start_n | output | 1 | Start-phase strobe, active low |
| msburst_n | output | 1 | Master burst strobe, active low |
| ex16_n | input | 1 | Slave claims a 16-bit path, active low |
| ex32_n | input | 1 | Slave claims a 32-bit path, active low |
| slburst_n | input | 1 | Slave can burst, active low |
| exrdy | input | 1 | Slave ready, active high |
| bus_din | input | 32 | Data from the bus |
| bus_dout | output | 32 | Data to the bus |
| bus_doe | output | 1 | Output enable for `bus_dout` |

## Verification
`start_n`, the first address and the byte enables change in the cycle after the accepting edge. An address advance shows in the cycle after the ready midpoint. `rd_valid` and `done` come one cycle after the completing edge, and the write hold lasts exactly one cycle after that edge. The bench samples every output on the falling clock edge. It steps a phase model that it advances from its own slave responses (wait counts, claim, burst capability), so each check lands in the cycle where the requirement places the change. `exrdy`, the claim lines and `bus_din` are randomised in every half-cycle in which they must be ignored.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
    // Half-bus-clock phases of one transfer: start phase halves and command phase halves.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TS_A = 3'd1,
        PH_TS_B = 3'd2,
        PH_TC_A = 3'd3,
        PH_TC_B = 3'd4
    } phase_t;
endpackage

// File: rtl/bbm_ctrl.sv
// Phase sequencer: steps through start and command half-phases, counts the
// words left, negotiates burst on the first start phase, samples the slave
// ready line at each command midpoint and drives the master burst strobe.
// Assumes clk runs at twice the bus clock, so that each phase half is one cycle.
module bbm_ctrl
    import bbm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_burst,
    input  logic             ex16_n,
    input  logic             ex32_n,
    input  logic             slburst_n,
    input  logic             exrdy,
    output phase_t           phase,
    output logic             accept,
    output logic             mid,
    output logic             fin,
    output logic             adv,
    output logic             load_w,
    output logic             hold_set,
    output logic             burst_on,
    output logic             msburst_n,
    output logic             done,
    output logic             err
);
    logic [CNT_W-1:0] rem;
    logic             first_q;
    logic             want_burst;
    logic             rdy_q;
    logic             last;
    logic             claim_ok;
    phase_t           nxt;

    assign last     = (rem == CNT_W'(1));
    assign claim_ok = !ex16_n || !ex32_n;
    assign accept   = (phase == PH_IDLE) && req_valid && (req_count != '0);
    assign mid      = (phase == PH_TC_A);
    assign fin      = (phase == PH_TC_B) && rdy_q;
    assign adv      = mid && exrdy && !last;
    assign load_w   = (phase == PH_TS_A) || (fin && burst_on && !last);
    assign hold_set = fin && !burst_on;

    // Next-phase selection.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: if (accept) nxt = PH_TS_A;
            PH_TS_A: nxt = PH_TS_B;
            PH_TS_B: nxt = claim_ok ? PH_TC_A : PH_IDLE;
            PH_TC_A: nxt = PH_TC_B;
            PH_TC_B: begin
                if (!rdy_q)        nxt = PH_TC_A;
                else if (last)     nxt = PH_IDLE;
                else if (burst_on) nxt = PH_TC_A;
                else               nxt = PH_TS_A;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // Word count, burst negotiation, ready sample, strobes and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem        <= '0;
            first_q    <= 1'b0;
            want_burst <= 1'b0;
            burst_on   <= 1'b0;
            rdy_q      <= 1'b0;
            msburst_n  <= 1'b1;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= fin && last;
            if (accept) begin
                rem        <= req_count;
                first_q    <= 1'b1;
                want_burst <= req_burst;
                burst_on   <= 1'b0;
                err        <= 1'b0;
            end
            if (phase == PH_TS_B) begin
                first_q <= 1'b0;
                if (!claim_ok)
                    err <= 1'b1;
                else if (first_q && want_burst && !slburst_n && !last)
                    burst_on <= 1'b1;
            end
            if (mid) begin
                rdy_q <= exrdy;
                if (burst_on) msburst_n <= exrdy && last;
            end
            if (fin) begin
                rem <= rem - CNT_W'(1);
                if (last) begin
                    burst_on  <= 1'b0;
                    msburst_n <= 1'b1;
                end
            end
        end
    end

    // R3
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (phase == PH_IDLE));
    // R4
    wait_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && !exrdy) |=> (phase == PH_TC_B && !fin));
    // R6
    burst_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && phase == PH_TC_B && !last) |-> !msburst_n);
    // R7
    burst_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && fin && last) |-> msburst_n);
endmodule

// File: rtl/bbm_addr.sv
// Address generator: loads the start address on acceptance and steps it by
// one word when the sequencer reports a ready midpoint with words remaining.
// Assumes the step equals the bus word size in bytes.
module bbm_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic          adv,
    input  logic          mid,
    input  logic          exrdy,
    output logic [AW-1:0] addr_q
);
    // Address register: load or pipeline forward.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
        else if (adv)    addr_q <= addr_q + AW'(STEP);
    end

    // R4
    addr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && !exrdy) |=> $stable(addr_q));
    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (addr_q == $past(addr_q) + AW'(STEP)));
endmodule

// File: rtl/bbm_data.sv
// Data path: loads write words into the bus output register, drives the
// output enable over the write window plus a one-cycle hold after standard
// cycles, and captures read words at completing edges.
// Assumes the user keeps the next write word on wr_data ahead of each load.
module bbm_data
    import bbm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic          write_q,
    input  logic          load_w,
    input  logic          hold_set,
    input  logic          fin,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    output logic          wr_pop,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic hold_q;
    logic drive;

    assign drive   = write_q && (phase == PH_TS_B || phase == PH_TC_A || phase == PH_TC_B);
    assign bus_doe = drive || hold_q;

    // Write word register, take pulse and hold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dout <= '0;
            wr_pop   <= 1'b0;
            hold_q   <= 1'b0;
        end else begin
            wr_pop <= load_w && write_q;
            hold_q <= hold_set && write_q;
            if (load_w && write_q) bus_dout <= wr_data;
        end
    end

    // Read capture at each completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= fin && !write_q;
            if (fin && !write_q) rd_data <= bus_din;
        end
    end

    // R11
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_set && write_q) |=> (bus_doe && $stable(bus_dout)));
    // R10
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !write_q |-> !bus_doe);
endmodule

// File: rtl/burst_bus_master.sv
// Top of the bus master sequencer: latches the request attributes, ties the
// sequencer, address generator and data path together and decodes strobes.
// Assumes a 2x internal clock and a slave that holds its claim lines valid
// at the end of each start phase.
module burst_bus_master
    import bbm_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_burst,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_pop,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [AW-1:0]    bus_addr,
    output logic [DW/8-1:0]  bus_be_n,
    output logic             bus_mio,
    output logic             bus_write,
    output logic             start_n,
    output logic             msburst_n,
    input  logic             ex16_n,
    input  logic             ex32_n,
    input  logic             slburst_n,
    input  logic             exrdy,
    input  logic [DW-1:0]    bus_din,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_doe
);
    localparam int BEW  = DW / 8;
    localparam int STEP = DW / 8;

    phase_t phase;
    logic   accept, mid, fin, adv, load_w, hold_set, burst_on;
    logic   dir_q, mem_q;

    assign req_ready = (phase == PH_IDLE);
    assign busy      = (phase != PH_IDLE);
    assign start_n   = !(phase == PH_TS_A || phase == PH_TS_B);
    assign bus_be_n  = busy ? '0 : {BEW{1'b1}};
    assign bus_write = dir_q;
    assign bus_mio   = mem_q;

    // Request attribute latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            mem_q <= 1'b0;
        end else if (accept) begin
            dir_q <= req_write;
            mem_q <= req_mem;
        end
    end

    bbm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_count(req_count),
        .req_burst(req_burst), .ex16_n(ex16_n), .ex32_n(ex32_n),
        .slburst_n(slburst_n), .exrdy(exrdy), .phase(phase), .accept(accept),
        .mid(mid), .fin(fin), .adv(adv), .load_w(load_w), .hold_set(hold_set),
        .burst_on(burst_on), .msburst_n(msburst_n), .done(done), .err(err)
    );

    bbm_addr #(.AW(AW), .STEP(STEP)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .adv(adv), .mid(mid), .exrdy(exrdy), .addr_q(bus_addr)
    );

    bbm_data #(.DW(DW)) u_data (
        .clk(clk), .rst_n(rst_n), .phase(phase), .write_q(dir_q),
        .load_w(load_w), .hold_set(hold_set), .fin(fin), .wr_data(wr_data),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R8
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_write));
    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n) |=> !start_n);
    // R2
    start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_n && $past(!start_n)) |=> start_n);
    // R6
    burst_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msburst_n |-> (busy && !burst_on == 1'b0));
endmodule

// File: tb/burst_bus_master_test.sv
module burst_bus_master_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_mem, req_burst;
    logic [31:0] req_addr;
    logic [7:0]  req_count;
    logic [31:0] wr_data, rd_data, bus_addr, bus_din, bus_dout;
    logic        wr_pop, rd_valid, busy, done, err;
    logic [3:0]  bus_be_n;
    logic        bus_mio, bus_write, start_n, msburst_n;
    logic        ex16_n, ex32_n, slburst_n, exrdy, bus_doe;

    int checks = 0;
    int failures = 0;
    int widx;
    int wt[16];
    logic [31:0] wtag;

    always #5 clk = ~clk;

    burst_bus_master uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
        .req_count(req_count), .req_burst(req_burst), .wr_data(wr_data),
        .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .done(done), .err(err), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_mio(bus_mio), .bus_write(bus_write), .start_n(start_n),
        .msburst_n(msburst_n), .ex16_n(ex16_n), .ex32_n(ex32_n),
        .slburst_n(slburst_n), .exrdy(exrdy), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    function automatic logic [31:0] wfun(input int k);
        return wtag ^ (32'(k) * 32'h0101_0007);
    endfunction

    function automatic logic [31:0] rfun(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One request against a modelled slave; the phase model comes from the requirements.
    task automatic do_req(input logic [31:0] a, input bit w, input bit mem, input bit brq,
                          input bit sl, input bit claim, input int n);
        int  ph, nph, bk, wl;
        bit  bursting, msb_on, abort, rd_pend, rdy;
        logic [31:0] rd_exp;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'd1);
        req_addr = a; req_write = w; req_mem = mem; req_count = 8'(n);
        req_burst = brq; req_valid = 1'b1;
        wtag = 32'($urandom); widx = 0; wr_data = wfun(0);
        @(negedge clk);
        req_valid = 1'b0;
        ph = 1; bk = 0; wl = 0; bursting = 0; msb_on = 0; abort = 0;
        rd_pend = 0; rdy = 0; rd_exp = '0;
        while (ph != 0) begin
            nph = ph;
            chk(busy == 1'b1, "R1 busy", 32'(busy), 32'd1);
            chk(bus_write == w, "R8 direction", 32'(bus_write), 32'(w));
            if (rd_pend) begin
                chk(rd_valid == 1'b1 && rd_data == rd_exp, "R9 read word", rd_data, rd_exp);
                rd_pend = 0;
            end else begin
                chk(rd_valid == 1'b0, "R9 no stray read", 32'(rd_valid), 32'd0);
            end
            ex16_n = 1'($urandom); ex32_n = 1'($urandom);
            slburst_n = 1'($urandom); exrdy = 1'($urandom); bus_din = $urandom;
            case (ph)
                1: begin
                    chk(start_n == 1'b0, "R2 start low", 32'(start_n), 32'd0);
                    chk(bus_addr == a + 32'(4 * bk), "R2 address", bus_addr, a + 32'(4 * bk));
                    chk(bus_mio == mem && bus_be_n == 4'h0, "R2 mio/be", {bus_be_n, 3'b0, bus_mio}, {4'h0, 3'b0, mem});
                    chk(err == 1'b0, "R3 err cleared", 32'(err), 32'd0);
                    chk(bus_doe == (w && bk > 0), "R11 hold into next start", 32'(bus_doe), 32'(w && bk > 0));
                    if (w && bk > 0)
                        chk(bus_dout == wfun(bk - 1), "R11 held data", bus_dout, wfun(bk - 1));
                    nph = 2;
                end
                2: begin
                    chk(start_n == 1'b0, "R2 start second half", 32'(start_n), 32'd0);
                    chk(bus_doe == w, "R10 write drive", 32'(bus_doe), 32'(w));
                    if (w) chk(bus_dout == wfun(bk), "R10 write word", bus_dout, wfun(bk));
                    if (claim) begin
                        if ($urandom % 2 == 0) begin ex16_n = 1'b0; ex32_n = 1'b1; end
                        else begin ex16_n = 1'b1; ex32_n = 1'b0; end
                    end else begin
                        ex16_n = 1'b1; ex32_n = 1'b1;
                    end
                    slburst_n = !sl;
                    if (!claim) begin
                        abort = 1; nph = 0;
                    end else begin
                        if (bk == 0 && brq && sl && n > 1) bursting = 1;
                        wl = wt[bk]; nph = 3;
                    end
                end
                3: begin
                    chk(start_n == 1'b1, "R2 start released", 32'(start_n), 32'd1);
                    chk(msburst_n == !(bursting && msb_on), "R6 strobe first half",
                        32'(msburst_n), 32'(!(bursting && msb_on)));
                    chk(bus_addr == a + 32'(4 * bk), "R4 address before midpoint", bus_addr, a + 32'(4 * bk));
                    chk(bus_doe == w, "R10 drive in command", 32'(bus_doe), 32'(w));
                    rdy = (wl == 0);
                    exrdy = rdy;
                    if (bursting) msb_on = 1;
                    nph = 4;
                end
                default: begin
                    chk(start_n == 1'b1, "R4 no start in command", 32'(start_n), 32'd1);
                    if (rdy && bk < n - 1)
                        chk(bus_addr == a + 32'(4 * (bk + 1)), "R5 pipelined address", bus_addr, a + 32'(4 * (bk + 1)));
                    else
                        chk(bus_addr == a + 32'(4 * bk), "R4 address held", bus_addr, a + 32'(4 * bk));
                    if (bursting)
                        chk(msburst_n == (rdy && bk == n - 1), "R7 burst strobe second half",
                            32'(msburst_n), 32'(rdy && bk == n - 1));
                    else
                        chk(msburst_n == 1'b1, "R6 no burst strobe", 32'(msburst_n), 32'd1);
                    chk(bus_doe == w, "R10 drive second half", 32'(bus_doe), 32'(w));
                    if (w) chk(bus_dout == wfun(bk), "R10 word on bus", bus_dout, wfun(bk));
                    if (rdy) begin
                        if (!w) begin
                            bus_din = rfun(a + 32'(4 * bk));
                            rd_exp = bus_din; rd_pend = 1;
                        end
                        bk++;
                        nph = (bk == n) ? 0 : (bursting ? 3 : 1);
                    end else begin
                        wl--; nph = 3;
                    end
                end
            endcase
            if (wr_pop) begin widx++; wr_data = wfun(widx); end
            ph = nph;
            @(negedge clk);
        end
        chk(busy == 1'b0, "R1 busy falls", 32'(busy), 32'd0);
        chk(done == !abort, "R12 done pulse", 32'(done), 32'(!abort));
        chk(err == abort, "R3 error flag", 32'(err), 32'(abort));
        chk(start_n == 1'b1 && msburst_n == 1'b1 && bus_be_n == 4'hF, "R2 idle strobes",
            {start_n, msburst_n, bus_be_n}, 6'h3F);
        if (rd_pend)
            chk(rd_valid == 1'b1 && rd_data == rd_exp, "R9 last read word", rd_data, rd_exp);
        else
            chk(rd_valid == 1'b0, "R3 no read on abort", 32'(rd_valid), 32'd0);
        chk(bus_doe == (w && !bursting && !abort), "R11 final hold", 32'(bus_doe),
            32'(w && !bursting && !abort));
        if (w && !bursting && !abort)
            chk(bus_dout == wfun(n - 1), "R11 final held word", bus_dout, wfun(n - 1));
        @(negedge clk);
        chk(bus_doe == 1'b0 && done == 1'b0, "R11 release", {bus_doe, done}, 2'b00);
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7219));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_mem = 1'b0;
        req_count = '0; req_burst = 1'b0; wr_data = '0; bus_din = '0;
        ex16_n = 1'b1; ex32_n = 1'b1; slburst_n = 1'b1; exrdy = 1'b0; wtag = '0; widx = 0;
        for (int i = 0; i < 16; i++) wt[i] = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && start_n == 1 && msburst_n == 1 && bus_doe == 0 && done == 0 && err == 0
            && req_ready == 1 && bus_be_n == 4'hF, "R2 reset state",
            {busy, start_n, msburst_n, bus_doe, done, err, req_ready}, 7'b0110001);
        rst_n = 1'b1;

        // R1: zero count is ignored
        @(negedge clk);
        req_valid = 1'b1; req_count = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b0 && req_ready == 1'b1, "R1 zero count ignored", 32'(busy), 32'd0);

        // Directed: standard writes with waits (R4, R10, R11)
        wt[0] = 1; wt[1] = 0; wt[2] = 2;
        do_req(32'h0000_1000, 1, 1, 0, 1, 1, 3);
        // Burst read with wait on the third word (R5, R6, R7, R9)
        wt[0] = 0; wt[1] = 0; wt[2] = 1; wt[3] = 0; wt[4] = 0;
        do_req(32'h0040_0010, 0, 1, 1, 1, 1, 5);
        // Burst write, waits at first and last word
        wt[0] = 2; wt[1] = 0; wt[2] = 0; wt[3] = 1;
        do_req(32'h8000_0FF0, 1, 0, 1, 1, 1, 4);
        // Abort: nobody claims (R3), then err clears on next request
        do_req(32'h0000_2000, 0, 1, 1, 1, 0, 3);
        wt[0] = 0;
        do_req(32'h0000_3000, 0, 1, 1, 1, 1, 1);
        // Burst requested but slave cannot burst (R6)
        wt[0] = 0; wt[1] = 1; wt[2] = 0;
        do_req(32'hFFFF_FFF8, 1, 1, 1, 0, 1, 3);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            int n;
            n = 1 + int'($urandom % 7);
            for (int k = 0; k < 16; k++) wt[k] = ($urandom % 3 == 0) ? int'($urandom % 3) : 0;
            do_req({$urandom, 2'b00} , 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), ($urandom % 10) != 0, n);
        end
        finish_run();
    end
endmodule